// File: doc/BRIEF.md
# Multi-width serial flash read engine

This block is the read path on the device side of a serial flash that can use one, two or four data lines. An opcode decoder upstream selects the read mode and pulses `start` while chip select is low. The engine then collects a 24-bit byte address on the rising serial-clock edges. It waits through a programmable number of dummy clocks and returns bytes from a small internal byte store on the falling edges. It continues until chip select is released.

Everything runs on one fast system clock. The serial clock arrives as two single-cycle enable pulses, `sck_rise` and `sck_fall`. The four IO lines are split into an input bus, an output bus and a per-line output enable. A simple byte write port fills the store, which plays the part of the array's program path. Addresses wrap to zero at the top of the store, so the host can stream for as long as it likes.

Top module: `qspi_read_engine`

## Requirements
- R1: `mode` is sampled with `start` and selects the address width and the data width. 0 is the basic read (address 1 bit, data 1 bit). 1 is the fast read (1/1). 2 is dual output (1/2). 3 is quad output (1/4). 4 is dual I/O (2/2). 5 is quad I/O (4/4). Codes 6 and 7 behave as code 1. The 24-bit address is received most significant bit first, one chunk per `sck_rise`. A 1-bit address is taken from IO0, a 2-bit address from {IO1,IO0}, and a 4-bit address from {IO3..IO0}.
- R2: The basic read has no dummy clocks, whatever `latency` holds. Its first data bit is driven on the first `sck_fall` after the last address rise.
- R3: Every mode other than the basic read inserts exactly `latency` dummy rising edges (0 to 15) after the address. The value is sampled with `start`. The first data chunk is driven on the `sck_fall` after the last dummy rise.
- R4: Data bytes are shifted out most significant chunk first, one chunk per `sck_fall`, and `io_out` updates on the clock edge that samples the pulse. A 1-bit chunk is driven on IO1. A 2-bit chunk goes on {IO1,IO0}. A 4-bit chunk goes on {IO3..IO0}.
- R5: Bytes come from sequentially increasing addresses, starting at the received one, for as long as chip select stays low.
- R6: After the byte at the top of the store (index 255 by default), the next byte comes from index 0.
- R7: Address bits above the store index width (bits 23..8 by default) do not affect which byte is returned.
- R8: `io_oe` is 0 in idle, during the address phase and during the dummy phase. From the first data chunk on, it is 4'b0010, 4'b0011 or 4'b1111 for 1-, 2- or 4-bit data.
- R9: `cs_n` high at any point returns the engine to idle. On the next clock `io_oe` and `io_out` are 0, and a following `start` begins a fresh read.
- R10: After reset every stored byte reads 8'hFF. A `mem_we` pulse writes `mem_wdata` to index `mem_waddr`, and later reads return the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck_rise | input | 1 | One-cycle pulse marking a serial-clock rising edge |
| sck_fall | input | 1 | One-cycle pulse marking a serial-clock falling edge |
| start | input | 1 | Decoded read command, accepted in idle with cs_n low |
| mode | input | 3 | Read mode code, sampled with start |
| latency | input | 4 | Dummy clock count, sampled with start |
| io_in | input | 4 | Sampled IO3..IO0 levels |
| io_out | output | 4 | Driven IO3..IO0 values |
| io_oe | output | 4 | Per-line output enable |
| mem_we | input | 1 | Byte store write strobe |
| mem_waddr | input | 8 | Byte store write index |
| mem_wdata | input | 8 | Byte store write data |

## Verification
Each `sck_rise` is taken by the engine on the clock edge where the pulse is high. Each data chunk appears on `io_out`/`io_oe` on the edge that samples its `sck_fall`. The bench therefore samples the output at the falling clock edge that follows that pulse, before it drives the next serial edge. The first data sample is due on the fall that follows exactly 24/w address rises plus the expected dummy count. Any extra or missing dummy clock shifts every returned byte, so the scoreboard sees the miscount. The abort cases check the outputs one clock after `cs_n` rises.

// File: rtl/qre_pkg.sv
package qre_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_DUMMY = 2'd2,
        PH_DATA  = 2'd3
    } qre_phase_e;

    // log2 of lane counts: 0 -> 1 line, 1 -> 2 lines, 2 -> 4 lines
    typedef struct packed {
        logic [1:0] addr_lg;
        logic [1:0] data_lg;
        logic       has_dummy;
    } qre_mode_t;

    function automatic qre_mode_t qre_decode(input logic [2:0] code);
        qre_mode_t r;
        case (code)
            3'd0:    r = '{addr_lg: 2'd0, data_lg: 2'd0, has_dummy: 1'b0};
            3'd2:    r = '{addr_lg: 2'd0, data_lg: 2'd1, has_dummy: 1'b1};
            3'd3:    r = '{addr_lg: 2'd0, data_lg: 2'd2, has_dummy: 1'b1};
            3'd4:    r = '{addr_lg: 2'd1, data_lg: 2'd1, has_dummy: 1'b1};
            3'd5:    r = '{addr_lg: 2'd2, data_lg: 2'd2, has_dummy: 1'b1};
            default: r = '{addr_lg: 2'd0, data_lg: 2'd0, has_dummy: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qre_store.sv
module qre_store #(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [7:0]        rd_data
);
    localparam int MEM_BYTES = 1 << MEM_AW;

    logic [7:0] bank [MEM_BYTES];

    for (genvar g = 0; g < MEM_BYTES; g++) begin : g_byte
        logic [7:0] cell_q;
        logic       hit;
        assign hit = we && (waddr == MEM_AW'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cell_q <= 8'hFF;
            else if (hit) cell_q <= wdata;
        end
        assign bank[g] = cell_q;
    end

    assign rd_data = bank[rd_idx];

    // R10
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> bank[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/qre_lanes.sv
module qre_lanes (
    input  logic [3:0] io_in,
    input  logic [1:0] addr_lg,
    input  logic [1:0] data_lg,
    input  logic [7:0] out_byte,
    output logic [3:0] addr_bits,
    output logic [3:0] drive_val,
    output logic [3:0] drive_mask
);
    always_comb begin
        case (addr_lg)
            2'd0:    addr_bits = {3'b000, io_in[0]};
            2'd1:    addr_bits = {2'b00, io_in[1:0]};
            default: addr_bits = io_in;
        endcase
        case (data_lg)
            2'd0: begin
                drive_val  = {2'b00, out_byte[7], 1'b0};
                drive_mask = 4'b0010;
            end
            2'd1: begin
                drive_val  = {2'b00, out_byte[7:6]};
                drive_mask = 4'b0011;
            end
            default: begin
                drive_val  = out_byte[7:4];
                drive_mask = 4'b1111;
            end
        endcase
    end

endmodule

// File: rtl/qre_seq.sv
module qre_seq
    import qre_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int MEM_AW = 8,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [LAT_W-1:0]  latency,
    input  logic [3:0]        addr_bits,
    input  logic [3:0]        drive_val,
    input  logic [3:0]        drive_mask,
    input  logic [7:0]        rd_byte,
    output logic [MEM_AW-1:0] rd_idx,
    output logic [1:0]        addr_lg,
    output logic [1:0]        data_lg,
    output logic [7:0]        out_byte,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe
);
    localparam int CNT_W = $clog2(ADDR_W + 1);

    typedef struct packed {
        qre_phase_e        phase;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [LAT_W-1:0]  dummy;
        logic [1:0]        aw;
        logic [1:0]        dw;
        logic [7:0]        shreg;
        logic [2:0]        chunk;
        logic [3:0]        io_out;
        logic [3:0]        io_oe;
    } st_t;

    st_t              s_q, s_d;
    qre_mode_t        cfg;
    logic             load;
    logic [3:0]       aw_bits, dw_bits;
    logic [MEM_AW-1:0] nxt_idx;

    always_comb begin
        s_d      = s_q;
        cfg      = qre_decode(mode);
        load     = (s_q.phase == PH_DATA) && sck_fall && (s_q.chunk == 3'd0);
        out_byte = load ? rd_byte : s_q.shreg;
        aw_bits  = 4'd1 << s_q.aw;
        dw_bits  = 4'd1 << s_q.dw;
        nxt_idx  = s_q.addr[MEM_AW-1:0] + MEM_AW'(1);
        if (cs_n) begin
            s_d = '0;
        end else begin
            case (s_q.phase)
                PH_IDLE: if (start) begin
                    s_d.phase = PH_ADDR;
                    s_d.addr  = '0;
                    s_d.aw    = cfg.addr_lg;
                    s_d.dw    = cfg.data_lg;
                    s_d.cnt   = CNT_W'(ADDR_W >> cfg.addr_lg);
                    s_d.dummy = cfg.has_dummy ? latency : '0;
                    s_d.chunk = 3'd0;
                end
                PH_ADDR: if (sck_rise) begin
                    s_d.addr = (s_q.addr << aw_bits) | ADDR_W'(addr_bits);
                    s_d.cnt  = s_q.cnt - CNT_W'(1);
                    if (s_q.cnt == CNT_W'(1))
                        s_d.phase = (s_q.dummy != '0) ? PH_DUMMY : PH_DATA;
                end
                PH_DUMMY: if (sck_rise) begin
                    s_d.dummy = s_q.dummy - LAT_W'(1);
                    if (s_q.dummy == LAT_W'(1)) s_d.phase = PH_DATA;
                end
                default: if (sck_fall) begin
                    s_d.io_out = drive_val;
                    s_d.io_oe  = drive_mask;
                    s_d.shreg  = out_byte << dw_bits;
                    if (load) begin
                        s_d.chunk = 3'((4'd8 >> s_q.dw) - 4'd1);
                        s_d.addr  = {{(ADDR_W-MEM_AW){1'b0}}, nxt_idx};
                    end else begin
                        s_d.chunk = s_q.chunk - 3'd1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_idx  = s_q.addr[MEM_AW-1:0];
    assign addr_lg = s_q.aw;
    assign data_lg = s_q.dw;
    assign io_out  = s_q.io_out;
    assign io_oe   = s_q.io_oe;

    // R1
    addr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_ADDR && sck_rise && !cs_n && s_q.cnt > CNT_W'(1))
        |=> (s_q.phase == PH_ADDR && s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));

    // R3
    dummy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_DUMMY && sck_rise && !cs_n && s_q.dummy > LAT_W'(1))
        |=> s_q.phase == PH_DUMMY);

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cs_n && s_q.addr[MEM_AW-1:0] == {MEM_AW{1'b1}})
        |=> s_q.addr == '0);

    // R8
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_DATA) |-> s_q.io_oe == 4'b0000);

    // R8
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.io_oe == 4'b0000 || s_q.io_oe == 4'b0010 ||
        s_q.io_oe == 4'b0011 || s_q.io_oe == 4'b1111);

    // R9
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (s_q.phase == PH_IDLE && s_q.io_oe == 4'b0000 && s_q.io_out == 4'b0000));

endmodule

// File: rtl/qspi_read_engine.sv
module qspi_read_engine #(
    parameter int ADDR_W = 24,
    parameter int MEM_AW = 8,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [LAT_W-1:0]  latency,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic              mem_we,
    input  logic [MEM_AW-1:0] mem_waddr,
    input  logic [7:0]        mem_wdata
);
    logic [MEM_AW-1:0] rd_idx;
    logic [7:0]        rd_byte, out_byte;
    logic [1:0]        addr_lg, data_lg;
    logic [3:0]        addr_bits, drive_val, drive_mask;

    qre_store #(.MEM_AW(MEM_AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_byte)
    );

    qre_lanes u_lanes (
        .io_in      (io_in),
        .addr_lg    (addr_lg),
        .data_lg    (data_lg),
        .out_byte   (out_byte),
        .addr_bits  (addr_bits),
        .drive_val  (drive_val),
        .drive_mask (drive_mask)
    );

    qre_seq #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .LAT_W(LAT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .start      (start),
        .mode       (mode),
        .latency    (latency),
        .addr_bits  (addr_bits),
        .drive_val  (drive_val),
        .drive_mask (drive_mask),
        .rd_byte    (rd_byte),
        .rd_idx     (rd_idx),
        .addr_lg    (addr_lg),
        .data_lg    (data_lg),
        .out_byte   (out_byte),
        .io_out     (io_out),
        .io_oe      (io_oe)
    );

endmodule

// File: tb/qspi_read_engine_bench.sv
module qspi_read_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck_rise = 1'b0, sck_fall = 1'b0, start = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [3:0] latency = 4'd0;
    logic [3:0] io_in = 4'd0;
    logic [3:0] io_out, io_oe;
    logic       mem_we = 1'b0;
    logic [7:0] mem_waddr = 8'd0, mem_wdata = 8'd0;

    always #10 clk = ~clk;

    qspi_read_engine u_qspi_read_engine (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .start(start), .mode(mode), .latency(latency), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] bm [256];
    logic [7:0] exp_q [$];
    string      req_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int aw_of(input int m);
        return (m == 4) ? 1 : (m == 5) ? 2 : 0;
    endfunction
    function automatic int dw_of(input int m);
        return (m == 2 || m == 4) ? 1 : (m == 3 || m == 5) ? 2 : 0;
    endfunction
    function automatic logic [3:0] mask_of(input int dw);
        return (dw == 0) ? 4'b0010 : (dw == 1) ? 4'b0011 : 4'b1111;
    endfunction

    // monitor state
    bit         mon_on = 0;
    int         tb_dw = 0;
    logic [3:0] exp_mask = 4'b0010;
    logic       fall_seen = 1'b0;
    logic [7:0] acc;
    int         nch = 0;
    bit         oe_bad = 0;

    always @(posedge clk) fall_seen <= sck_fall;

    always @(negedge clk) begin
        if (!mon_on) begin
            nch = 0; oe_bad = 0;
        end else if (fall_seen) begin
            case (tb_dw)
                0:       acc = {acc[6:0], io_out[1]};
                1:       acc = {acc[5:0], io_out[1:0]};
                default: acc = {acc[3:0], io_out};
            endcase
            if (io_oe !== exp_mask) oe_bad = 1;
            nch++;
            if (nch == (8 >> tb_dw)) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected byte", acc, 0);
                end else begin
                    logic [7:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(acc === e, r, acc, e);
                    check(!oe_bad, "R8 data oe mask", io_oe, exp_mask);
                end
                nch = 0; oe_bad = 0;
            end
        end
    end

    task automatic rise(input logic [3:0] v);
        @(negedge clk); io_in = v; sck_rise = 1'b1;
        @(negedge clk); sck_rise = 1'b0;
    endtask
    task automatic fall();
        @(negedge clk); sck_fall = 1'b1;
        @(negedge clk); sck_fall = 1'b0;
    endtask

    // sends command, address and dummy clocks; leaves engine ready for data falls
    task automatic begin_read(input int m, input logic [23:0] a, input int lat);
        int aw, w, n, nd;
        aw = aw_of(m); w = 1 << aw; n = 24 / w;
        nd = (m == 0) ? 0 : lat;
        @(negedge clk); cs_n = 1'b0; start = 1'b1; mode = 3'(m); latency = 4'(lat);
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < n + nd; i++) begin
            logic [3:0] v;
            v = (i < n) ? 4'((a >> (24 - (i + 1) * w)) & ((1 << w) - 1)) : 4'd0;
            if (i > 0) fall();
            rise(v);
        end
        check(io_oe == 4'b0000, "R8 oe low before data", io_oe, 0);
    endtask

    task automatic do_read(input int m, input logic [23:0] a, input int lat,
                           input int nbytes, input string req);
        int dw;
        dw = dw_of(m);
        for (int k = 0; k < nbytes; k++) begin
            exp_q.push_back(bm[8'(a[7:0] + k)]);
            req_q.push_back(req);
        end
        tb_dw = dw; exp_mask = mask_of(dw);
        begin_read(m, a, lat);
        mon_on = 1;
        for (int c = 0; c < nbytes * (8 >> dw); c++) begin
            fall();
            rise(4'd0);
        end
        @(negedge clk);
        mon_on = 0;
        check(exp_q.size() == 0, {req, " all bytes returned"}, exp_q.size(), 0);
        exp_q.delete(); req_q.delete();
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R5 watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) bm[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(io_oe == 4'b0000 && io_out == 4'b0000, "R8 reset outputs", {io_oe, io_out}, 0);
        // R10: erased contents after reset
        do_read(0, 24'h000003, 0, 2, "R10 erased read");
        // R10: load the store
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            mem_we = 1'b1; mem_waddr = 8'(i); mem_wdata = 8'((i * 29 + 7) & 255);
            bm[i] = 8'((i * 29 + 7) & 255);
        end
        @(negedge clk); mem_we = 1'b0;
        do_read(0, 24'h000010, 10, 3, "R2 basic read ignores latency");
        do_read(1, 24'h000040, 8, 3, "R3 fast read latency 8");
        do_read(1, 24'h000041, 0, 2, "R3 fast read latency 0");
        do_read(6, 24'h000050, 3, 2, "R1 reserved code as fast");
        do_read(2, 24'h000060, 4, 3, "R4 dual output");
        do_read(3, 24'h000070, 15, 3, "R4 quad output latency 15");
        do_read(4, 24'h000081, 2, 3, "R1 dual io address");
        do_read(5, 24'h0000A7, 6, 3, "R1 quad io address");
        do_read(0, 24'h000020, 0, 12, "R5 long sequential read");
        do_read(5, 24'h0000FD, 6, 5, "R6 wrap at top");
        do_read(0, 24'h0000FF, 0, 2, "R6 basic wrap");
        do_read(2, 24'hAB0020, 1, 3, "R7 upper address ignored");

        // R9: abort during address phase
        @(negedge clk); cs_n = 1'b0; start = 1'b1; mode = 3'd5; latency = 4'd2;
        @(negedge clk); start = 1'b0;
        rise(4'hA); fall(); rise(4'h5);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        check(io_oe == 4'b0000 && io_out == 4'b0000, "R9 abort in address", {io_oe, io_out}, 0);
        do_read(5, 24'h000033, 2, 2, "R9 read after address abort");

        // R9: abort during data phase
        begin_read(0, 24'h000090, 0);
        for (int c = 0; c < 3; c++) begin fall(); rise(4'd0); end
        check(io_oe == 4'b0010, "R8 single data oe", io_oe, 4'b0010);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        check(io_oe == 4'b0000 && io_out == 4'b0000, "R9 abort in data", {io_oe, io_out}, 0);
        do_read(3, 24'h000090, 5, 2, "R9 read after data abort");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule